// File: doc/BRIEF.md
# Floating-Point Exception Status Flag Unit

This block keeps the floating-point status flags of a single-precision arithmetic unit. Each time the datapath completes an operation, it reports six raw exception indications: invalid, overflow, underflow, output-denormal, divide-by-zero and inexact. The block folds them into one summary flag and five sticky flags. The summary flag is rewritten by every completion. The five sticky flags are only ever set by operations.

The block also fixes up the result word. When an operation signals invalid, the raw result is replaced by a quiet-NaN code that depends on the operation class and, for fused multiply-add and multiply-subtract, on what kind of operands caused the fault. The corrected result comes out one cycle after the completion strobe.

Software can rewrite the flags with a 16-bit command word that carries a value field and a mask field. The flag register is visible at all times on `flags_o`. Bit positions are [5] summary, [4] invalid, [3] overflow, [2] divide-by-zero, [1] underflow, [0] inexact.

Top module: `fpflag_unit`

## Requirements
- R1: Under synchronous active-low reset, all six flags read zero and `res_valid_o` is low.
- R2: On every completion (`op_done_i`) the summary flag (bit 5) becomes 1 if any of the six exception indications is high, and 0 if none is high.
- R3: On a completion, invalid sets bit 4, overflow sets bit 3 and divide-by-zero sets bit 2. No completion ever clears bits 4..0, and with no completion and no command the flags hold.
- R4: Bit 1 (underflow) is set by underflow or by output-denormal. Bit 0 (inexact) is set by inexact or by output-denormal.
- R5: `res_valid_o` pulses exactly one cycle after each completion, carrying `res_o`. `res_o` equals `raw_res_i` when invalid is low, when an operand of a two-operand operation is a NaN, or when `op_kind_i` is 6 or 7. The `op_kind_i` encodings are: 0 add, 1 subtract, 2 multiply, 3 divide, 4 multiply-add, 5 multiply-subtract.
- R6: When invalid is high and neither `opa_i` nor `opb_i` is a NaN, the result is replaced as follows: add and subtract give 0x7FC00001, multiply gives 0x7FC00002, divide gives 0x7FC00008.
- R7: For kinds 4 and 5 with invalid high, the result is chosen in this order:
  - any NaN among the three operands gives 0x7FC00000;
  - otherwise an infinity times a zero, in either order, gives 0x7FC00002. An operand with exponent field 0 counts as zero here.
- R8: For kinds 4 and 5 with invalid high and no case of R7 applying, the result is 0x7FC00001 when an infinite `opa_i` or `opb_i` meets an infinite `opc_i` whose effective sign is opposite to the product's sign. The effective sign of the addend is inverted for kind 5. Otherwise `res_o` is the raw result.
- R9: On `upd_en_i`, bits 5..1 each become value AND mask. Values sit in word bits 7..3 and masks in word bits 15..11, in flag order summary, invalid, overflow, divide-by-zero, underflow. Word bits 9..8 and 1..0 are ignored.
- R10: On `upd_en_i`, the inexact flag becomes word bit 2 when mask bit 10 is set, and holds when bit 10 is clear.
- R11: If `upd_en_i` and `op_done_i` are high in the same cycle, the flags follow the command only. The result of the operation is still delivered per R5 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_done_i | input | 1 | Datapath completion strobe |
| op_kind_i | input | 3 | Operation class (R5 encoding) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| opc_i | input | 32 | Addend for fused operations |
| raw_res_i | input | 32 | Uncorrected datapath result |
| exc_invalid_i | input | 1 | Invalid-operation indication |
| exc_overflow_i | input | 1 | Overflow indication |
| exc_underflow_i | input | 1 | Underflow indication |
| exc_out_denorm_i | input | 1 | Output-denormal indication |
| exc_divzero_i | input | 1 | Divide-by-zero indication |
| exc_inexact_i | input | 1 | Inexact indication |
| upd_en_i | input | 1 | Flag-update command strobe |
| upd_word_i | input | 16 | Packed value/mask command word |
| res_valid_o | output | 1 | Corrected result valid |
| res_o | output | 32 | Corrected result |
| flags_o | output | 6 | Flag register {summary, invalid, overflow, div-by-zero, underflow, inexact} |

## Verification
Every flag bit drives `flags_o` directly. A wrong update therefore shows at the ports on the cycle right after the completion or command that caused it, and a lost sticky bit shows on any later read. A wrong NaN-code decision shows as a wrong `res_o` on the single cycle when `res_valid_o` is high. For that reason each operation's result and the flags are compared together at that one cycle, against a running model of the flags. Command cases are read back one cycle after the command. This includes the case where a command collides with a completion, and masked-off fields, where the bench confirms that the bits the command did not touch kept their values.

// File: rtl/fpflag_pkg.sv
// Package: shared constants, types and operand classifiers for the
// floating-point status flag unit. Assumes single-precision operands.
package fpflag_pkg;

    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int NFLAG  = 6;
    localparam int CMD_W  = 16;

    // flag bit positions inside the flag register (match the command word order)
    localparam int FL_FS = 5;
    localparam int FL_FI = 4;
    localparam int FL_FV = 3;
    localparam int FL_FZ = 2;
    localparam int FL_FU = 1;
    localparam int FL_FX = 0;

    // command word field origins
    localparam int VAL_LSB  = 2;
    localparam int MASK_LSB = 10;

    // substitute result codes
    localparam logic [FP_W-1:0] NAN_QUIET = 32'h7FC0_0000;
    localparam logic [FP_W-1:0] NAN_ADD   = 32'h7FC0_0001;
    localparam logic [FP_W-1:0] NAN_MUL   = 32'h7FC0_0002;
    localparam logic [FP_W-1:0] NAN_DIV   = 32'h7FC0_0008;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_MADD = 3'd4,
        OP_MSUB = 3'd5,
        OP_CMP  = 3'd6,
        OP_CVT  = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } fp_t;

    // exponent all ones with non-zero fraction
    function automatic logic is_nan(input fp_t v);
        return (&v.expo) && (|v.man);
    endfunction

    // exponent all ones with zero fraction
    function automatic logic is_inf(input fp_t v);
        return (&v.expo) && !(|v.man);
    endfunction

    // zero after squashing input denormals (exponent field zero)
    function automatic logic is_zero_sq(input fp_t v);
        return !(|v.expo);
    endfunction

endpackage

// File: rtl/fpflag_nan_pick.sv
// Module: fpflag_nan_pick
// Chooses the delivered result word. When the invalid indication is
// present, replaces the raw result with an operation-specific NaN code.
// Assumes: purely combinational; operands are raw single-precision words.
module fpflag_nan_pick
    import fpflag_pkg::*;
(
    input  logic [2:0]      kind_i,
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    input  logic [FP_W-1:0] c_i,
    input  logic [FP_W-1:0] raw_i,
    input  logic            invalid_i,
    output logic [FP_W-1:0] res_o
);

    fp_t      a_f, b_f, c_f;
    op_kind_e kind;
    logic     any_nan_ab, any_nan_abc, inf_times_zero, inf_clash, addend_flip;

    // Operand classification shared by all branches
    always_comb begin
        a_f            = fp_t'(a_i);
        b_f            = fp_t'(b_i);
        c_f            = fp_t'(c_i);
        kind           = op_kind_e'(kind_i);
        any_nan_ab     = is_nan(a_f) || is_nan(b_f);
        any_nan_abc    = any_nan_ab || is_nan(c_f);
        inf_times_zero = (is_inf(a_f) && is_zero_sq(b_f)) ||
                         (is_zero_sq(a_f) && is_inf(b_f));
        addend_flip    = (kind == OP_MSUB);
        inf_clash      = ((&a_f.expo) || (&b_f.expo)) && (&c_f.expo) &&
                         (a_f.sign ^ b_f.sign ^ c_f.sign ^ addend_flip);
    end

    // Result substitution by operation class
    always_comb begin
        res_o = raw_i;
        if (invalid_i) begin
            unique case (kind)
                OP_ADD, OP_SUB: if (!any_nan_ab) res_o = NAN_ADD;
                OP_MUL:         if (!any_nan_ab) res_o = NAN_MUL;
                OP_DIV:         if (!any_nan_ab) res_o = NAN_DIV;
                OP_MADD, OP_MSUB: begin
                    if (any_nan_abc)         res_o = NAN_QUIET;
                    else if (inf_times_zero) res_o = NAN_MUL;
                    else if (inf_clash)      res_o = NAN_ADD;
                end
                default: res_o = raw_i;
            endcase
        end
    end

endmodule

// File: rtl/fpflag_op_merge.sv
// Module: fpflag_op_merge
// Computes the flag register value after a completed operation: the
// summary bit is rewritten, the other five only accumulate.
// Assumes: exc_i is {invalid, overflow, underflow, out-denormal, div0, inexact}.
module fpflag_op_merge
    import fpflag_pkg::*;
(
    input  logic [NFLAG-1:0] cur_i,
    input  logic [5:0]       exc_i,
    output logic [NFLAG-1:0] nxt_o
);

    logic inv, ovf, unf, odn, dz, inx;

    // Unpack indications and fold them into the flags
    always_comb begin
        {inv, ovf, unf, odn, dz, inx} = exc_i;
        nxt_o        = cur_i;
        nxt_o[FL_FS] = |exc_i;
        nxt_o[FL_FI] = cur_i[FL_FI] | inv;
        nxt_o[FL_FV] = cur_i[FL_FV] | ovf;
        nxt_o[FL_FZ] = cur_i[FL_FZ] | dz;
        nxt_o[FL_FU] = cur_i[FL_FU] | unf | odn;
        nxt_o[FL_FX] = cur_i[FL_FX] | inx | odn;
    end

endmodule

// File: rtl/fpflag_cmd_dec.sv
// Module: fpflag_cmd_dec
// Decodes a packed value/mask command word into the next flag register
// value. Flags above inexact take value AND mask; inexact is replaced only
// when its mask is set.
// Assumes: word layout values at VAL_LSB.., masks at MASK_LSB.. .
module fpflag_cmd_dec
    import fpflag_pkg::*;
(
    input  logic [NFLAG-1:0] cur_i,
    input  logic [CMD_W-1:0] word_i,
    output logic [NFLAG-1:0] nxt_o
);

    logic unused_bits;
    assign unused_bits = ^{word_i[MASK_LSB-1:VAL_LSB+NFLAG], word_i[VAL_LSB-1:0]};

    // Masked-and fields for summary through underflow
    for (genvar i = 1; i < NFLAG; i++) begin : g_and
        assign nxt_o[i] = word_i[VAL_LSB+i] & word_i[MASK_LSB+i];
    end

    // Inexact: clear-then-set under its own mask, otherwise keep
    assign nxt_o[FL_FX] = word_i[MASK_LSB+FL_FX] ? word_i[VAL_LSB+FL_FX] : cur_i[FL_FX];

endmodule

// File: rtl/fpflag_unit.sv
// Module: fpflag_unit (top)
// Holds the floating-point status flags, updates them on each completed
// operation or software command, and registers the NaN-corrected result.
// Assumes: synchronous active-low reset; a command takes precedence over a
// completion in the same cycle; result latency is one cycle.
module fpflag_unit
    import fpflag_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_done_i,
    input  logic [2:0]            op_kind_i,
    input  logic [31:0]           opa_i,
    input  logic [31:0]           opb_i,
    input  logic [31:0]           opc_i,
    input  logic [31:0]           raw_res_i,
    input  logic                  exc_invalid_i,
    input  logic                  exc_overflow_i,
    input  logic                  exc_underflow_i,
    input  logic                  exc_out_denorm_i,
    input  logic                  exc_divzero_i,
    input  logic                  exc_inexact_i,
    input  logic                  upd_en_i,
    input  logic [15:0]           upd_word_i,
    output logic                  res_valid_o,
    output logic [31:0]           res_o,
    output logic [5:0]            flags_o
);

    logic [NFLAG-1:0] flags_q, flags_op, flags_cmd;
    logic [FP_W-1:0]  res_d, res_q;
    logic             valid_q;
    logic [5:0]       exc_vec;

    assign exc_vec = {exc_invalid_i, exc_overflow_i, exc_underflow_i,
                      exc_out_denorm_i, exc_divzero_i, exc_inexact_i};

    fpflag_nan_pick u_pick (
        .kind_i    (op_kind_i),
        .a_i       (opa_i),
        .b_i       (opb_i),
        .c_i       (opc_i),
        .raw_i     (raw_res_i),
        .invalid_i (exc_invalid_i),
        .res_o     (res_d)
    );

    fpflag_op_merge u_merge (
        .cur_i (flags_q),
        .exc_i (exc_vec),
        .nxt_o (flags_op)
    );

    fpflag_cmd_dec u_cmd (
        .cur_i  (flags_q),
        .word_i (upd_word_i),
        .nxt_o  (flags_cmd)
    );

    // Flag register: command first, then completion, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)          flags_q <= '0;
        else if (upd_en_i)   flags_q <= flags_cmd;
        else if (op_done_i)  flags_q <= flags_op;
    end

    // Result register and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= op_done_i;
            if (op_done_i) res_q <= res_d;
        end
    end

    assign res_valid_o = valid_q;
    assign res_o       = res_q;
    assign flags_o     = flags_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> res_valid_o);                                        // R5
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done_i |=> !res_valid_o);                                      // R5
    AST_PASS_NO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !exc_invalid_i) |=> res_o == $past(raw_res_i));      // R5
    AST_SUMMARY_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !upd_en_i) |=> flags_o[5] == $past(|exc_vec));       // R2
    AST_STICKY_NEVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done_i && !upd_en_i) |=>
            ((flags_o[4:0] & $past(flags_o[4:0])) == $past(flags_o[4:0]))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_done_i && !upd_en_i) |=> $stable(flags_o));                   // R3
    AST_CMD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> flags_o[5:1] == $past(upd_word_i[7:3] & upd_word_i[15:11])); // R9
    AST_FX_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && !upd_word_i[10]) |=> flags_o[0] == $past(flags_o[0])); // R10

endmodule

// File: tb/fpflag_unit_tb.sv
`timescale 1ns/1ps
module fpflag_unit_tb;

    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] ZRO  = 32'h0000_0000;
    localparam logic [31:0] DEN  = 32'h0000_0001;
    localparam logic [31:0] SNAN = 32'h7F80_0001;
    localparam logic [31:0] RAW  = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done_i = 1'b0;
    logic [2:0]  op_kind_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, opc_i = '0, raw_res_i = '0;
    logic [5:0]  exc = '0;
    logic        upd_en_i = 1'b0;
    logic [15:0] upd_word_i = '0;
    logic        res_valid_o;
    logic [31:0] res_o;
    logic [5:0]  flags_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] exp_flags = '0;

    logic [31:0] q_res[$];
    logic [5:0]  q_flg[$];
    string       q_req[$];

    always #2 clk = ~clk;

    fpflag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_done_i(op_done_i), .op_kind_i(op_kind_i),
        .opa_i(opa_i), .opb_i(opb_i), .opc_i(opc_i), .raw_res_i(raw_res_i),
        .exc_invalid_i(exc[5]), .exc_overflow_i(exc[4]), .exc_underflow_i(exc[3]),
        .exc_out_denorm_i(exc[2]), .exc_divzero_i(exc[1]), .exc_inexact_i(exc[0]),
        .upd_en_i(upd_en_i), .upd_word_i(upd_word_i),
        .res_valid_o(res_valid_o), .res_o(res_o), .flags_o(flags_o)
    );

    // flag model on completion; e = {inv,ovf,unf,odn,dz,inx}
    function automatic logic [5:0] model_op(logic [5:0] f, logic [5:0] e);
        logic [5:0] n;
        n[5] = |e;
        n[4] = f[4] | e[5];
        n[3] = f[3] | e[4];
        n[2] = f[2] | e[1];
        n[1] = f[1] | e[3] | e[2];
        n[0] = f[0] | e[0] | e[2];
        return n;
    endfunction

    function automatic logic [5:0] model_cmd(logic [5:0] f, logic [15:0] w);
        logic [5:0] n;
        for (int i = 1; i < 6; i++) n[i] = w[2+i] & w[10+i];
        n[0] = w[10] ? w[2] : f[0];
        return n;
    endfunction

    task automatic check(logic ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // driver: one completion, expected result pushed to the scoreboard
    task automatic do_op(logic [2:0] k, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [31:0] raw, logic [5:0] e, logic [31:0] exp_res, string req);
        op_kind_i = k; opa_i = a; opb_i = b; opc_i = c; raw_res_i = raw; exc = e;
        op_done_i = 1'b1;
        exp_flags = model_op(exp_flags, e);
        q_res.push_back(exp_res); q_flg.push_back(exp_flags); q_req.push_back(req);
        @(negedge clk);
        op_done_i = 1'b0; exc = '0;
    endtask

    task automatic do_cmd(logic [15:0] w, string req);
        upd_word_i = w; upd_en_i = 1'b1;
        exp_flags = model_cmd(exp_flags, w);
        @(negedge clk);
        upd_en_i = 1'b0;
        check(flags_o == exp_flags, req, "flags after command", {26'd0, flags_o}, {26'd0, exp_flags});
    endtask

    // command and completion collide: command decides the flags
    task automatic do_both(logic [15:0] w, logic [5:0] e, string req);
        upd_word_i = w; upd_en_i = 1'b1;
        op_kind_i = 3'd0; opa_i = ONE; opb_i = ONE; opc_i = ZRO; raw_res_i = RAW; exc = e;
        op_done_i = 1'b1;
        exp_flags = model_cmd(exp_flags, w);
        q_res.push_back(RAW); q_flg.push_back(exp_flags); q_req.push_back(req);
        @(negedge clk);
        upd_en_i = 1'b0; op_done_i = 1'b0; exc = '0;
    endtask

    // monitor: compare result and flags on each valid pulse
    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R5", "unexpected valid", 32'd1, 32'd0);
            end else begin
                logic [31:0] er;
                logic [5:0]  ef;
                string       rq;
                er = q_res.pop_front(); ef = q_flg.pop_front(); rq = q_req.pop_front();
                check(res_o == er, rq, "result", res_o, er);
                check(flags_o == ef, rq, "flags", {26'd0, flags_o}, {26'd0, ef});
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flags_o == 6'd0, "R1", "flags in reset", {26'd0, flags_o}, 32'd0);
        check(res_valid_o == 1'b0, "R1", "valid in reset", {31'd0, res_valid_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(3'd0, ONE, ONE, ZRO, 32'h4000_0000, 6'b000000, 32'h4000_0000, "R5 clean add");
        do_op(3'd0, PINF, NINF, ZRO, RAW, 6'b100000, 32'h7FC0_0001, "R6 add inf-inf");
        do_op(3'd1, PINF, PINF, ZRO, RAW, 6'b100000, 32'h7FC0_0001, "R6 sub inf-inf");
        do_op(3'd2, PINF, ZRO, ZRO, RAW, 6'b100000, 32'h7FC0_0002, "R6 mul inf*0");
        do_op(3'd3, ZRO, ZRO, ZRO, RAW, 6'b100000, 32'h7FC0_0008, "R6 div 0/0");
        do_op(3'd0, SNAN, ONE, ZRO, 32'h7FC0_0005, 6'b100000, 32'h7FC0_0005, "R5 nan input pass");
        do_op(3'd6, ONE, ZRO, ZRO, RAW, 6'b100000, RAW, "R5 kind 6 pass");
        do_op(3'd2, ONE, ONE, ZRO, ONE, 6'b000001, ONE, "R4 inexact");
        do_op(3'd0, ONE, ZRO, ZRO, ONE, 6'b000000, ONE, "R2 summary clears");
        do_cmd(16'hFC00, "R9 clear all");
        do_op(3'd2, DEN, DEN, ZRO, ZRO, 6'b000100, ZRO, "R4 out-denorm");
        do_op(3'd2, ONE, ONE, ZRO, PINF, 6'b010001, PINF, "R3 overflow");
        do_op(3'd3, ONE, ZRO, ZRO, PINF, 6'b000010, PINF, "R3 divzero");
        do_op(3'd0, ONE, ONE, ZRO, ONE, 6'b001000, ONE, "R3 underflow keeps others");
        do_op(3'd4, SNAN, ONE, ONE, RAW, 6'b100000, 32'h7FC0_0000, "R7 madd nan");
        do_op(3'd5, ONE, ONE, SNAN, RAW, 6'b100000, 32'h7FC0_0000, "R7 msub nan addend");
        do_op(3'd4, PINF, ZRO, ONE, RAW, 6'b100000, 32'h7FC0_0002, "R7 madd inf*0");
        do_op(3'd4, DEN, NINF, ONE, RAW, 6'b100000, 32'h7FC0_0002, "R7 madd den*inf");
        do_op(3'd4, PINF, ONE, NINF, RAW, 6'b100000, 32'h7FC0_0001, "R8 madd clash");
        do_op(3'd5, PINF, ONE, PINF, RAW, 6'b100000, 32'h7FC0_0001, "R8 msub flip clash");
        do_op(3'd5, PINF, ONE, NINF, RAW, 6'b100000, RAW, "R8 msub same sign pass");
        do_op(3'd4, PINF, ONE, PINF, RAW, 6'b100000, RAW, "R8 madd same sign pass");
        do_cmd(16'hFCA8, "R9 value and mask");
        do_cmd(16'hFBFF, "R10 fx unmasked holds");
        do_cmd(16'h0404, "R10 fx masked set");
        do_cmd(16'h0300, "R9 ignored bits");
        do_both(16'h0000, 6'b010000, "R11 command wins");
        do_op(3'd7, ONE, ONE, ZRO, ONE, 6'b000000, ONE, "R5 kind 7 clean");
        repeat (2) @(negedge clk);
        check(q_res.size() == 0, "R5", "scoreboard drained", q_res.size(), 32'd0);
        finish_run();
    end

endmodule